// File: doc/BRIEF.md
# ISA Bus Slave Access Decoder

This block sits between a 16-bit ISA expansion bus and the register file and buffer store of a peripheral. On every cycle of its internal clock it looks at the system address, the address-enable line and the four bus strobes. It decides whether the host is reading or writing the peripheral, and through which of two windows. It then presents clean, registered select, read-enable and write-enable signals to the logic behind it, together with the byte lanes in use and the captured write data. It also drives the output enable for the shared data bus.

Two windows are decoded side by side. The I/O window is 16 bytes at a programmable base aligned to 16 bytes, and holds eight 16-bit ports. It is always active and cannot be turned off. The memory window is 4 Kbytes at a programmable base aligned to 4 Kbytes. It holds the peripheral's registers and buffers and is decoded only while its enable input is set. The base addresses and the memory enable are plain configuration inputs, expected to be held steady by the surrounding logic. No data stream passes through the block, so it has no valid/ready handshake. Every output follows its inputs by exactly one clock.

Top module: `isa_slave_decoder`

## Requirements
- R1: While reset is active and on the first sampled cycle after it, io_rd, io_wr, mem_rd, mem_wr, sd_oe, byte_en, io_port, mem_off and wr_data are all zero.
- R2: When aen is low, sa[15:4] equals io_base, ior_n is low and iow_n is high, io_rd is 1 one clock later and io_port equals sa[3:1].
- R3: When aen is low, sa[15:4] equals io_base, iow_n is low and ior_n is high, io_wr is 1 one clock later and io_port equals sa[3:1].
- R4: When aen is high, no access of either window is produced, whatever the address and strobes.
- R5: An address whose bits 15:4 differ from io_base produces no I/O access. Bits sa[19:16] take no part in the I/O comparison.
- R6: When mem_en is 1, aen is low and sa[19:12] equals mem_base, memr_n low with memw_n high gives mem_rd one clock later, and memw_n low with memr_n high gives mem_wr one clock later. In both cases mem_off equals sa[11:0].
- R7: When mem_en is 0, no memory access is produced, and I/O decoding behaves as in R2 and R3.
- R8: During any decoded access, byte_en[0] is the inverse of sa[0] and byte_en[1] is the inverse of sbhe_n. With no access, byte_en, io_port and mem_off are zero.
- R9: If both strobes of one window are low together, that window produces neither a read nor a write.
- R10: When an I/O strobe is low with an I/O address hit, any memory access in the same cycle is suppressed, so the I/O window takes priority.
- R11: sd_oe is 1 exactly when io_rd or mem_rd is 1. sd_out equals rd_data while sd_oe is 1 and is zero otherwise.
- R12: wr_data takes the value of sd_in in the same clock that io_wr or mem_wr becomes 1, and holds its value in every cycle with no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sa | input | 20 | System address bus |
| sbhe_n | input | 1 | High byte enable, active low |
| aen | input | 1 | Address enable; high marks a non-CPU cycle |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| io_base | input | 12 | Bits 15:4 of the I/O window base |
| mem_en | input | 1 | Enables decoding of the memory window |
| mem_base | input | 8 | Bits 19:12 of the memory window base |
| sd_in | input | 16 | Data bus value driven by the host |
| rd_data | input | 16 | Read value returned by the selected register |
| sd_out | output | 16 | Data bus value driven by the block |
| sd_oe | output | 1 | Data bus output enable; low leaves the bus in high impedance |
| io_rd | output | 1 | I/O port read enable |
| io_wr | output | 1 | I/O port write enable |
| io_port | output | 3 | Selected I/O port |
| mem_rd | output | 1 | Memory window read enable |
| mem_wr | output | 1 | Memory window write enable |
| mem_off | output | 12 | Byte offset inside the memory window |
| byte_en | output | 2 | Byte lanes used: bit 0 low byte, bit 1 high byte |
| wr_data | output | 16 | Write data captured with a write |

## Verification
The hardest situation to reach from the ports is a cycle where both windows hit at once, or where two strobes of one window are low together. Uniform random addresses almost never hit a 16-byte window, let alone both windows together. The stimulus therefore draws the address from a mix: the I/O window, the memory window, and addresses that are one bit away from the I/O base. The memory base is placed so that its 4-Kbyte range contains the I/O window, which lets one address hit both windows. Strobes are drawn independently, so double-strobe cycles occur often. Directed cases then fix the exact collisions, the aen-high case and the mem_en-off case.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
  } strobe_t;

  // A strobe pair is turned into a request only when exactly one is low.
  function automatic strobe_t qualify(input logic rd_n, input logic wr_n);
    strobe_t s;
    s.rd = ~rd_n & wr_n;
    s.wr = ~wr_n & rd_n;
    return s;
  endfunction

endpackage

// File: rtl/isa_io_window.sv
module isa_io_window #(
  parameter int IO_AW  = 16,
  parameter int IO_WIN = 4
) (
  input  logic [IO_AW-1:IO_WIN] sa_hi,
  input  logic [IO_AW-1:IO_WIN] base,
  input  logic                  aen,
  input  logic                  ior_n,
  input  logic                  iow_n,
  output isa_dec_pkg::strobe_t  req,
  output logic                  claim
);
  import isa_dec_pkg::*;

  logic    hit;
  strobe_t q;

  always_comb begin
    hit   = ~aen && (sa_hi == base);
    q     = qualify(ior_n, iow_n);
    req   = hit ? q : '0;
    claim = hit && (~ior_n || ~iow_n);
  end

endmodule

// File: rtl/isa_mem_window.sv
module isa_mem_window #(
  parameter int MEM_AW  = 20,
  parameter int MEM_WIN = 12
) (
  input  logic [MEM_AW-1:MEM_WIN] sa_hi,
  input  logic [MEM_AW-1:MEM_WIN] base,
  input  logic                    enable,
  input  logic                    aen,
  input  logic                    memr_n,
  input  logic                    memw_n,
  input  logic                    io_claim,
  output isa_dec_pkg::strobe_t    req
);
  import isa_dec_pkg::*;

  logic    hit;
  strobe_t q;

  always_comb begin
    hit = enable && ~aen && ~io_claim && (sa_hi == base);
    q   = qualify(memr_n, memw_n);
    req = hit ? q : '0;
  end

endmodule

// File: rtl/isa_access_reg.sv
module isa_access_reg #(
  parameter int MEM_WIN = 12,
  parameter int IO_WIN  = 4,
  parameter int DW      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  isa_dec_pkg::strobe_t io_req,
  input  isa_dec_pkg::strobe_t mem_req,
  input  logic [MEM_WIN-1:0]   sa_lo,
  input  logic                 sbhe_n,
  input  logic [DW-1:0]        sd_in,
  output logic                 io_rd,
  output logic                 io_wr,
  output logic [IO_WIN-2:0]    io_port,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [MEM_WIN-1:0]   mem_off,
  output logic [1:0]           byte_en,
  output logic                 oe,
  output logic [DW-1:0]        wr_data
);

  logic io_any, mem_any, any_wr;

  always_comb begin
    io_any  = io_req.rd | io_req.wr;
    mem_any = mem_req.rd | mem_req.wr;
    any_wr  = io_req.wr | mem_req.wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rd   <= 1'b0;
      io_wr   <= 1'b0;
      io_port <= '0;
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      mem_off <= '0;
      byte_en <= '0;
      oe      <= 1'b0;
      wr_data <= '0;
    end else begin
      io_rd   <= io_req.rd;
      io_wr   <= io_req.wr;
      io_port <= io_any ? sa_lo[IO_WIN-1:1] : '0;
      mem_rd  <= mem_req.rd;
      mem_wr  <= mem_req.wr;
      mem_off <= mem_any ? sa_lo : '0;
      byte_en <= (io_any | mem_any) ? {~sbhe_n, ~sa_lo[0]} : 2'b00;
      oe      <= io_req.rd | mem_req.rd;
      if (any_wr) wr_data <= sd_in;
    end
  end

  // R9
  io_rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));
  // R9
  mem_rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R10
  io_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((io_rd || io_wr) && (mem_rd || mem_wr)));
  // R11
  oe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe == (io_rd || mem_rd));
  // R12
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && !mem_wr) |-> $stable(wr_data));

endmodule

// File: rtl/isa_slave_decoder.sv
module isa_slave_decoder #(
  parameter int IO_AW   = 16,
  parameter int IO_WIN  = 4,
  parameter int MEM_AW  = 20,
  parameter int MEM_WIN = 12,
  parameter int DW      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MEM_AW-1:0]       sa,
  input  logic                    sbhe_n,
  input  logic                    aen,
  input  logic                    ior_n,
  input  logic                    iow_n,
  input  logic                    memr_n,
  input  logic                    memw_n,
  input  logic [IO_AW-1:IO_WIN]   io_base,
  input  logic                    mem_en,
  input  logic [MEM_AW-1:MEM_WIN] mem_base,
  input  logic [DW-1:0]           sd_in,
  input  logic [DW-1:0]           rd_data,
  output logic [DW-1:0]           sd_out,
  output logic                    sd_oe,
  output logic                    io_rd,
  output logic                    io_wr,
  output logic [IO_WIN-2:0]       io_port,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic [MEM_WIN-1:0]      mem_off,
  output logic [1:0]              byte_en,
  output logic [DW-1:0]           wr_data
);
  import isa_dec_pkg::*;

  strobe_t io_req, mem_req;
  logic    io_claim;

  isa_io_window #(.IO_AW(IO_AW), .IO_WIN(IO_WIN)) io_win_i (
    .sa_hi (sa[IO_AW-1:IO_WIN]),
    .base  (io_base),
    .aen   (aen),
    .ior_n (ior_n),
    .iow_n (iow_n),
    .req   (io_req),
    .claim (io_claim)
  );

  isa_mem_window #(.MEM_AW(MEM_AW), .MEM_WIN(MEM_WIN)) mem_win_i (
    .sa_hi    (sa[MEM_AW-1:MEM_WIN]),
    .base     (mem_base),
    .enable   (mem_en),
    .aen      (aen),
    .memr_n   (memr_n),
    .memw_n   (memw_n),
    .io_claim (io_claim),
    .req      (mem_req)
  );

  isa_access_reg #(.MEM_WIN(MEM_WIN), .IO_WIN(IO_WIN), .DW(DW)) acc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_req  (io_req),
    .mem_req (mem_req),
    .sa_lo   (sa[MEM_WIN-1:0]),
    .sbhe_n  (sbhe_n),
    .sd_in   (sd_in),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .io_port (io_port),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .mem_off (mem_off),
    .byte_en (byte_en),
    .oe      (sd_oe),
    .wr_data (wr_data)
  );

  always_comb sd_out = sd_oe ? rd_data : '0;

  // R4
  io_aen_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> $past(!aen));
  // R2
  io_rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |-> $past(!ior_n && iow_n));
  // R7
  mem_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> $past(mem_en && !aen));
  // R11
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> (sd_out == '0));

endmodule

// File: tb/isa_slave_decoder_tb.sv
module isa_slave_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] sa = '0;
  logic        sbhe_n = 1'b1, aen = 1'b0;
  logic        ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
  logic [11:0] io_base = 12'h030;
  logic        mem_en = 1'b0;
  logic [7:0]  mem_base = 8'hD0;
  logic [15:0] sd_in = '0, rd_data = 16'hA55A;
  logic [15:0] sd_out, wr_data;
  logic        sd_oe, io_rd, io_wr, mem_rd, mem_wr;
  logic [2:0]  io_port;
  logic [11:0] mem_off;
  logic [1:0]  byte_en;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_wd = '0;

  always #4 clk = ~clk;

  isa_slave_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .sa(sa), .sbhe_n(sbhe_n), .aen(aen),
    .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
    .io_base(io_base), .mem_en(mem_en), .mem_base(mem_base),
    .sd_in(sd_in), .rd_data(rd_data), .sd_out(sd_out), .sd_oe(sd_oe),
    .io_rd(io_rd), .io_wr(io_wr), .io_port(io_port), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_off(mem_off), .byte_en(byte_en), .wr_data(wr_data)
  );

  task automatic cmp(input string what, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected values from the requirements; returns packed
  // {io_rd, io_wr, io_port, mem_rd, mem_wr, mem_off, byte_en, oe, wr}
  function automatic logic [22:0] model();
    logic io_hit, io_claim, ir, iw, mr, mw, any_acc;
    logic [2:0] port;
    logic [11:0] off;
    logic [1:0] be;
    io_hit   = !aen && (sa[15:4] == io_base);
    ir       = io_hit && !ior_n && iow_n;
    iw       = io_hit && !iow_n && ior_n;
    io_claim = io_hit && (!ior_n || !iow_n);
    mr = mem_en && !aen && !io_claim && (sa[19:12] == mem_base) && !memr_n && memw_n;
    mw = mem_en && !aen && !io_claim && (sa[19:12] == mem_base) && !memw_n && memr_n;
    any_acc = ir | iw | mr | mw;
    port = (ir | iw) ? sa[3:1] : 3'd0;
    off  = (mr | mw) ? sa[11:0] : 12'd0;
    be   = any_acc ? {~sbhe_n, ~sa[0]} : 2'b00;
    return {ir, iw, port, mr, mw, off, be, ir | mr, iw | mw};
  endfunction

  task automatic step(input string req);
    logic [22:0] e;
    e = model();
    @(posedge clk);
    @(negedge clk);
    if (e[0]) exp_wd = sd_in;
    cmp("io_rd",   {req, "/R2"},  io_rd,   e[22]);
    cmp("io_wr",   {req, "/R3"},  io_wr,   e[21]);
    cmp("io_port", {req, "/R2"},  io_port, e[20:18]);
    cmp("mem_rd",  {req, "/R6"},  mem_rd,  e[17]);
    cmp("mem_wr",  {req, "/R6"},  mem_wr,  e[16]);
    cmp("mem_off", {req, "/R6"},  mem_off, e[15:4]);
    cmp("byte_en", {req, "/R8"},  byte_en, e[3:2]);
    cmp("sd_oe",   {req, "/R11"}, sd_oe,   e[1]);
    cmp("sd_out",  {req, "/R11"}, sd_out,  e[1] ? rd_data : 16'h0);
    cmp("wr_data", {req, "/R12"}, wr_data, exp_wd);
  endtask

  task automatic idle();
    ior_n = 1; iow_n = 1; memr_n = 1; memw_n = 1; aen = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    cmp("reset io_rd", "R1", io_rd, 0);
    cmp("reset sd_oe", "R1", sd_oe, 0);
    cmp("reset wr_data", "R1", wr_data, 0);
    ior_n = 0; sa = 20'h00300;
    @(negedge clk);
    cmp("reset io_rd held", "R1", io_rd, 0);
    idle();
    rst_n = 1;
    step("R1");

    // R2 read every port, R3 write
    for (int p = 0; p < 8; p++) begin
      sa = {4'h0, 12'h030, 3'(p), 1'b0}; sbhe_n = 0; ior_n = 0;
      step("R2"); idle();
      sa[0] = 1; sbhe_n = 1; iow_n = 0; sd_in = 16'h1100 + 16'(p);
      step("R3"); idle();
    end
    // R4 aen high blocks both windows
    mem_en = 1; mem_base = 8'h00;
    aen = 1; sa = 20'h00302; ior_n = 0; step("R4");
    aen = 1; ior_n = 1; memw_n = 0; step("R4"); idle();
    // R5 miss by one address bit; upper bits ignored for I/O
    sa = 20'h00312; ior_n = 0; mem_en = 0; step("R5");
    sa = 20'hF0304; step("R5"); idle();
    // R6 memory read and write
    mem_en = 1; mem_base = 8'hD0;
    sa = 20'hD0ABC; memr_n = 0; step("R6"); idle();
    sa = 20'hD0FFF; memw_n = 0; sd_in = 16'hBEEF; step("R6"); idle();
    // R7 disabled memory window, I/O still works
    mem_en = 0; sa = 20'hD0ABC; memr_n = 0; step("R7"); idle();
    sa = 20'h00306; iow_n = 0; sd_in = 16'h7777; step("R7"); idle();
    // R9 both strobes of one window low
    sa = 20'h00304; ior_n = 0; iow_n = 0; step("R9"); idle();
    mem_en = 1; sa = 20'hD0010; memr_n = 0; memw_n = 0; step("R9"); idle();
    // R10 both windows hit: I/O wins
    mem_base = 8'h00; sa = 20'h00308; ior_n = 0; memw_n = 0; sd_in = 16'h4242;
    step("R10"); idle();
    sa = 20'h00308; ior_n = 1; memr_n = 0; step("R10"); idle();

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 9));
      mem_en   = ($urandom_range(0, 3) != 0);
      mem_base = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'hD0;
      if (pick < 4)      sa = {4'($urandom), 12'h030, 4'($urandom)};
      else if (pick < 7) sa = {mem_base, 12'($urandom)};
      else if (pick < 9) sa = {4'h0, 12'h030 ^ (12'h1 << $urandom_range(0, 11)), 4'($urandom)};
      else               sa = 20'($urandom);
      sbhe_n = 1'($urandom); aen = ($urandom_range(0, 7) == 0);
      ior_n = 1'($urandom); iow_n = 1'($urandom);
      memr_n = 1'($urandom); memw_n = 1'($urandom);
      sd_in = 16'($urandom); rd_data = 16'($urandom);
      step("RND");
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule